// File: doc/BRIEF.md
# Magnitude Threshold Debounce Detector

This block watches a stream of unsigned field-magnitude samples, one per sample strobe, and raises an event only after the magnitude has stayed at or above a programmable 15-bit limit for a programmable number of sample periods. Because the debounce window is counted in samples, its length in time follows the sample rate. A reduced-rate setting halves the effective sample rate by acting on only every other strobe, which doubles the window for the same programmed count.

When a sample falls below the limit, the debounce counter responds in one of two ways, selected by software. In the gradual setting it steps down by one. In the strict setting it drops to zero. The block has three outputs of interest: a one-cycle event pulse, a sticky flag that holds until it is cleared, and the counter state kept internally. A three-register write port sets the limit, the below-limit behaviour and the debounce count.

The controller is a three-state machine. `ST_IDLE` means the counter is zero. `ST_COUNT` means the counter is partly filled. `ST_HELD` means the count has been reached and the event has fired. Its transitions are:

- *arm*: IDLE to COUNT, on an above-limit sample that does not yet reach the count.
- *fire*: IDLE or COUNT to HELD, on the sample that makes the counter equal the count.
- *hold*: HELD to HELD, on an above-limit sample.
- *drain*: COUNT or HELD to COUNT, on a below-limit sample that leaves the counter above zero.
- *drop*: any state to IDLE, on a below-limit sample that leaves the counter at zero.
- *restart*: any state to IDLE, on any register write.

Top module: `magdeb_top`

## Requirements
- R1: Register layout. Offset 0 bits [6:0] hold the upper 7 bits of the limit, and offset 0 bit 7 is the mode bit (0 = gradual, 1 = strict). Offset 1 holds the lower 8 bits of the limit. Offset 2 holds the 8-bit debounce count.
- R2: A sample counts as above the limit when `sample_mag >= limit`, with both values compared as 15-bit unsigned numbers (limit 0x7FFF: 0x7FFE is below, 0x7FFF is above).
- R3: Each acted-on above-limit sample raises the counter by one, saturating at the count. `evt_pulse` is high for exactly the one cycle after the sample on which the counter reaches the count, and does not repeat while samples stay above.
- R4: In gradual mode, each acted-on below-limit sample lowers the counter by one, stopping at zero without wrapping.
- R5: In strict mode, any acted-on below-limit sample clears the counter to zero.
- R6: With a count of zero, the first acted-on above-limit sample fires the event, and only once.
- R7: While `hybrid_en` is high, only alternate strobes are acted on, starting with the first strobe after `hybrid_en` rose. Skipped strobes leave the counter unchanged.
- R8: `evt_flag` sets together with `evt_pulse` and holds until `flag_clr` is sampled high. If a set and a clear land in the same cycle, the set wins.
- R9: A write to any of the three registers returns the counter to zero and the machine to IDLE.
- R10: After reset, `evt_pulse` and `evt_flag` are low and all registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| sample_vld | input | 1 | Sample strobe, one per output-data-rate period |
| sample_mag | input | 15 | Unsigned magnitude sample |
| hybrid_en | input | 1 | Reduced-rate mode: act on alternate strobes |
| flag_clr | input | 1 | Clears the sticky flag |
| evt_pulse | output | 1 | One-cycle event pulse |
| evt_flag | output | 1 | Sticky event flag |

## Verification
The counter is never visible directly, so a wrong count shows up only in when `evt_pulse` fires. A wrong step or a wrong clear moves the pulse earlier or later by at least one acted-on sample, and the error appears at the port no sooner than the next time the count is reached. A saturation fault shows up as a repeated pulse while the magnitude holds above the limit. A fault in the alternate-strobe logic shifts the firing sample by one strobe. The bench therefore drives sample sequences chosen so that every one of these faults moves a pulse to a specific sample it can name.

// File: rtl/magdeb_pkg.sv
package magdeb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HELD  = 2'd2
    } deb_state_e;

    localparam logic [1:0] OFS_LIM_HI = 2'd0;
    localparam logic [1:0] OFS_LIM_LO = 2'd1;
    localparam logic [1:0] OFS_COUNT  = 2'd2;
endpackage

// File: rtl/magdeb_regs.sv
module magdeb_regs
    import magdeb_pkg::*;
#(
    parameter int MAG_W = 15,
    parameter int DW    = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [1:0]       addr,
    input  logic [DW-1:0]    wdata,
    output logic [MAG_W-1:0] limit,
    output logic             strict,
    output logic [CNT_W-1:0] target,
    output logic             cfg_wr
);
    localparam int HI_W = MAG_W - DW;

    logic [HI_W-1:0]  lim_hi_q;
    logic [DW-1:0]    lim_lo_q;
    logic             strict_q;
    logic [CNT_W-1:0] target_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_hi_q <= '0;
            lim_lo_q <= '0;
            strict_q <= 1'b0;
            target_q <= '0;
        end else if (wr) begin
            unique case (addr)
                OFS_LIM_HI: begin
                    lim_hi_q <= wdata[HI_W-1:0];
                    strict_q <= wdata[DW-1];
                end
                OFS_LIM_LO: lim_lo_q <= wdata;
                OFS_COUNT:  target_q <= wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_wr = wr && (addr == OFS_LIM_HI || addr == OFS_LIM_LO || addr == OFS_COUNT);
    end

    assign limit  = {lim_hi_q, lim_lo_q};
    assign strict = strict_q;
    assign target = target_q;
endmodule

// File: rtl/magdeb_pace.sv
module magdeb_pace (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_vld,
    input  logic hybrid_en,
    output logic tick
);
    logic skip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            skip_q <= 1'b0;
        end else if (!hybrid_en) begin
            skip_q <= 1'b0;
        end else if (sample_vld) begin
            skip_q <= ~skip_q;
        end
    end

    always_comb begin
        tick = sample_vld && (!hybrid_en || !skip_q);
    end
endmodule

// File: rtl/magdeb_cmp.sv
module magdeb_cmp #(
    parameter int MAG_W = 15
) (
    input  logic [MAG_W-1:0] mag,
    input  logic [MAG_W-1:0] limit,
    output logic             above
);
    always_comb begin
        above = (mag >= limit);
    end
endmodule

// File: rtl/magdeb_fsm.sv
module magdeb_fsm
    import magdeb_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             above,
    input  logic             strict,
    input  logic [CNT_W-1:0] target,
    input  logic             cfg_wr,
    input  logic             flag_clr,
    output logic             evt_pulse,
    output logic             evt_flag,
    output logic [CNT_W-1:0] ctr
);
    deb_state_e       st_q, st_d;
    logic [CNT_W-1:0] ctr_q, ctr_d;
    logic [CNT_W-1:0] ctr_up, ctr_dn;
    logic             fire;
    logic             pulse_q, flag_q;

    always_comb begin
        ctr_up = (target == '0) ? '0 : ctr_q + 1'b1;
        if (strict || ctr_q == '0) begin
            ctr_dn = '0;
        end else begin
            ctr_dn = ctr_q - 1'b1;
        end
    end

    always_comb begin
        st_d  = st_q;
        ctr_d = ctr_q;
        fire  = 1'b0;
        if (cfg_wr) begin
            st_d  = ST_IDLE;
            ctr_d = '0;
        end else if (tick) begin
            unique case (st_q)
                ST_IDLE, ST_COUNT: begin
                    if (above) begin
                        ctr_d = ctr_up;
                        if (ctr_up == target) begin
                            fire = 1'b1;
                            st_d = ST_HELD;
                        end else begin
                            st_d = ST_COUNT;
                        end
                    end else begin
                        ctr_d = ctr_dn;
                        st_d  = (ctr_dn == '0) ? ST_IDLE : ST_COUNT;
                    end
                end
                ST_HELD: begin
                    if (!above) begin
                        ctr_d = ctr_dn;
                        st_d  = (ctr_dn == '0) ? ST_IDLE : ST_COUNT;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    ctr_d = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            ctr_q <= '0;
        end else begin
            st_q  <= st_d;
            ctr_q <= ctr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= fire;
            flag_q  <= fire | (flag_q & ~flag_clr);
        end
    end

    assign evt_pulse = pulse_q;
    assign evt_flag  = flag_q;
    assign ctr       = ctr_q;
endmodule

// File: rtl/magdeb_top.sv
module magdeb_top #(
    parameter int MAG_W = 15,
    parameter int DW    = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic             sample_vld,
    input  logic [MAG_W-1:0] sample_mag,
    input  logic             hybrid_en,
    input  logic             flag_clr,
    output logic             evt_pulse,
    output logic             evt_flag
);
    logic [MAG_W-1:0] limit;
    logic             strict;
    logic [CNT_W-1:0] target;
    logic             cfg_wr;
    logic             tick;
    logic             above;
    logic [CNT_W-1:0] ctr;

    magdeb_regs #(.MAG_W(MAG_W), .DW(DW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .limit(limit), .strict(strict), .target(target), .cfg_wr(cfg_wr)
    );

    magdeb_pace u_pace (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .hybrid_en(hybrid_en), .tick(tick)
    );

    magdeb_cmp #(.MAG_W(MAG_W)) u_cmp (
        .mag(sample_mag), .limit(limit), .above(above)
    );

    magdeb_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .above(above), .strict(strict),
        .target(target), .cfg_wr(cfg_wr), .flag_clr(flag_clr),
        .evt_pulse(evt_pulse), .evt_flag(evt_flag), .ctr(ctr)
    );
endmodule

// File: rtl/magdeb_chk.sv
module magdeb_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             sample_vld,
    input logic             above,
    input logic             strict,
    input logic             cfg_wr,
    input logic [CNT_W-1:0] ctr,
    input logic [CNT_W-1:0] target,
    input logic             flag_clr,
    input logic             evt_pulse,
    input logic             evt_flag
);
    assert_ctr_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctr <= target);

    assert_pulse_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !evt_pulse);

    assert_tick_from_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> sample_vld);

    assert_gradual_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !above && !strict && !cfg_wr) |=>
        (ctr == (($past(ctr) == '0) ? '0 : $past(ctr) - 1'b1)));

    assert_strict_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !above && strict && !cfg_wr) |=> (ctr == '0));

    assert_write_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (ctr == '0 && !evt_pulse));

    assert_flag_with_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> evt_flag);

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (!evt_flag || evt_pulse));
endmodule

bind magdeb_top magdeb_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sample_vld(sample_vld), .above(above),
    .strict(strict), .cfg_wr(cfg_wr), .ctr(ctr), .target(target),
    .flag_clr(flag_clr), .evt_pulse(evt_pulse), .evt_flag(evt_flag)
);

// File: tb/magdeb_top_bench.sv
module magdeb_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        sample_vld = 1'b0;
    logic [14:0] sample_mag = 15'd0;
    logic        hybrid_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        evt_pulse;
    logic        evt_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bit 15: expected pulse, bits [14:0]: magnitude (limit 100, count 3, gradual)
    localparam logic [15:0] VEC [0:16] = '{
        16'h0096, 16'h0064, 16'h0032, 16'h00C8, 16'h80C8, 16'h00C8,
        16'h0014, 16'h80C8, 16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0065, 16'h0065, 16'h0063, 16'h0065, 16'h8065
    };

    always #5 clk = ~clk;

    magdeb_top u_magdeb_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .sample_vld(sample_vld), .sample_mag(sample_mag),
        .hybrid_en(hybrid_en), .flag_clr(flag_clr),
        .evt_pulse(evt_pulse), .evt_flag(evt_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic smp(input logic [14:0] m);
        @(negedge clk);
        sample_vld = 1'b1; sample_mag = m;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int quiet_bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 pulse after reset", evt_pulse, 1'b0);
        chk("R10 flag after reset", evt_flag, 1'b0);

        // zero limit and zero count after reset: magnitude 0 fires at once
        smp(15'd0);
        chk("R10/R6 first sample fires", evt_pulse, 1'b1);
        chk("R8 flag sets with pulse", evt_flag, 1'b1);
        smp(15'd0);
        chk("R6 fires only once", evt_pulse, 1'b0);
        clr();
        chk("R8 clear drops flag", evt_flag, 1'b0);

        // vector walk: limit 100, gradual, count 3
        wr(2'd0, 8'h00); wr(2'd1, 8'd100); wr(2'd2, 8'd3);
        for (int i = 0; i < 17; i++) begin
            smp(VEC[i][14:0]);
            chk("R3/R4 vector pulse", evt_pulse, VEC[i][15]);
            chk("R8 vector flag", evt_flag, (i >= 4) ? 1'b1 : 1'b0);
        end

        // set wins over clear in the same cycle
        clr();
        wr(2'd2, 8'd1);
        @(negedge clk);
        sample_vld = 1'b1; sample_mag = 15'd200; flag_clr = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0; flag_clr = 1'b0;
        chk("R8 set beats clear pulse", evt_pulse, 1'b1);
        chk("R8 set beats clear flag", evt_flag, 1'b1);
        clr();

        // register write restarts the count
        wr(2'd2, 8'd3);
        smp(15'd200); smp(15'd200);
        wr(2'd2, 8'd3);
        smp(15'd200);
        chk("R9 restart no early pulse a", evt_pulse, 1'b0);
        smp(15'd200);
        chk("R9 restart no early pulse b", evt_pulse, 1'b0);
        smp(15'd200);
        chk("R9 fires after full count", evt_pulse, 1'b1);

        // strict mode clears on a low sample
        wr(2'd0, 8'h80);
        smp(15'd200); smp(15'd200); smp(15'd50);
        smp(15'd200); smp(15'd200);
        chk("R5 strict cleared no pulse", evt_pulse, 1'b0);
        smp(15'd200);
        chk("R5 strict fires after refill", evt_pulse, 1'b1);

        // reduced rate: skipped strobes do nothing
        wr(2'd0, 8'h00); wr(2'd2, 8'd2);
        @(negedge clk);
        hybrid_en = 1'b1;
        smp(15'd200);
        chk("R7 first acted sample", evt_pulse, 1'b0);
        smp(15'd0);
        chk("R7 skipped sample", evt_pulse, 1'b0);
        smp(15'd200);
        chk("R7 fires on alternate strobe", evt_pulse, 1'b1);
        @(negedge clk);
        hybrid_en = 1'b0;

        // largest count
        wr(2'd2, 8'd255);
        quiet_bad = 0;
        for (int k = 0; k < 254; k++) begin
            smp(15'd200);
            if (evt_pulse !== 1'b0) quiet_bad++;
        end
        chk("R3 no pulse before count 255", (quiet_bad != 0), 1'b0);
        smp(15'd200);
        chk("R3 pulse at count 255", evt_pulse, 1'b1);
        smp(15'd200);
        chk("R3 saturated no repeat", evt_pulse, 1'b0);

        // largest limit
        wr(2'd0, 8'h7F); wr(2'd1, 8'hFF); wr(2'd2, 8'd0);
        smp(15'h7FFE);
        chk("R2 just below max limit", evt_pulse, 1'b0);
        smp(15'h7FFF);
        chk("R2/R1 equal to max limit", evt_pulse, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule